// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects eight interrupt sources of a monitoring device into one status register, filters them through a mask register and drives a single interrupt line. Whenever a measurement is stored, the value arrives together with its high and low limits and a 3-bit channel index. A comparator decides whether the value lies outside the window, and the result sets or clears the status bit that the channel selects.

Software reaches three registers through a plain register port: status, mask and configuration. Most status bits are cleared by writing ones to them. Two bits are set by writing ones to them, which gives software a way to raise an interrupt itself. One bit follows a general-purpose input pin and ignores writes. Masking acts only on what a status bit contributes to the interrupt line. The stored bit still updates and can still be read. The unmasked bits are ORed, gated by an enable bit in the configuration register and registered onto an open-drain pull-down enable, so the line is active low.

Top module: `irq_status_ctrl`

## Requirements
- R1: A measurement with `meas_valid` high is out of limit when value > high limit or value < low limit (unsigned). A value equal to either limit is in limit. At the next clock edge the result is written into the selected status bit: 1 for out of limit, 0 for in limit.
- R2: `meas_chan` selects the status bit a measurement updates: 0 internal temperature, 1 software flag A, 2 software flag B, 3 internal thermal trip, 4 input pin, 5 external temperature, 6 external thermal trip, 7 diode fault. No other status bit changes.
- R3: A write to address 0 (status) clears each of bits 0, 3, 5, 6 and 7 whose write-data bit is 1. Bits written with 0 keep their value.
- R4: A write to address 0 sets bit 1 and bit 2 wherever the write-data bit is 1.
- R5: Status bit 4 equals the level that `gpi` had at the previous clock edge. Status writes and measurements on channel 4 have no effect on it.
- R6: The mask register at address 1 uses the same bit order as the status register. A mask bit of 1 removes that status bit from the interrupt line. The status readback is unchanged.
- R7: `int_oe` is 1 (line pulled low) one cycle after any status bit is 1 while its mask bit is 0 and configuration bit 1 (address 2) is 1. Otherwise `int_oe` is 0.
- R8: Clearing configuration bit 1 releases `int_oe` one cycle later and leaves the status contents unchanged.
- R9: If a measurement and a status write target the same bit in the same cycle, the measurement result is stored.
- R10: After reset, status, mask and configuration read as 0 and `int_oe` is 0. Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid | input | 1 | A measurement is presented this cycle |
| meas_chan | input | 3 | Status bit index the measurement updates |
| meas_value | input | 8 | Measured value |
| lim_hi | input | 8 | High limit for this measurement |
| lim_lo | input | 8 | Low limit for this measurement |
| gpi | input | 1 | General-purpose input pin level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 configuration |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| int_oe | output | 1 | Pull-down enable of the active-low interrupt line |

## Verification
The bench probes values exactly on each limit. A comparator that used >= or <= would flag those values as out of limit. It writes all ones to the status register to confirm that the write-one-to-clear bits clear, the software bits set and the pin bit ignores the write. A design that handled every bit the same way would lose or invent interrupts. It also presents a measurement and a conflicting status write in the same cycle; a design that let the write win would drop a fresh out-of-limit result. It then toggles the mask and the enable bit and confirms that the interrupt line follows while the status readback stays the same, which exposes designs that mask or clear the stored bits.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int N_SRC    = 8;
    localparam int DATA_W   = 8;
    localparam int CH_W     = $clog2(N_SRC);
    localparam int PIN_IDX  = 4;
    localparam int EN_BIT   = 1;
    localparam logic [N_SRC-1:0] SW_SET_BITS = 8'b0000_0110;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_CFG    = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] chan;
        logic            flag;
    } upd_t;

    function automatic logic outside_window(input logic [DATA_W-1:0] v,
                                            input logic [DATA_W-1:0] hi,
                                            input logic [DATA_W-1:0] lo);
        return (v > hi) || (v < lo);
    endfunction
endpackage

// File: rtl/irq_limit_cmp.sv
module irq_limit_cmp
    import irq_pkg::*;
(
    input  logic              valid,
    input  logic [CH_W-1:0]   chan,
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] hi,
    input  logic [DATA_W-1:0] lo,
    output upd_t              upd
);
    always_comb begin
        upd.valid = valid;
        upd.chan  = chan;
        upd.flag  = outside_window(value, hi, lo);
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_pkg::*;
#(
    parameter int               N       = N_SRC,
    parameter int               PIN     = PIN_IDX,
    parameter logic [N-1:0]     SET_MSK = SW_SET_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  upd_t         upd,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    input  logic         pin,
    output logic [N-1:0] status
);
    localparam logic [N-1:0] PIN_MSK = N'(1) << PIN;

    for (genvar i = 0; i < N; i++) begin : g_bit
        localparam logic [CH_W-1:0] IDX = CH_W'(i);
        if (i == PIN) begin : g_pin
            always_ff @(posedge clk) begin
                if (rst) status[i] <= 1'b0;
                else     status[i] <= pin;
            end
        end else begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)                              status[i] <= 1'b0;
                else if (upd.valid && upd.chan == IDX) status[i] <= upd.flag;
                else if (wr && wdata[i])              status[i] <= SET_MSK[i];
            end
        end
    end

    // R1 R2 R9: a measurement result lands in its selected bit
    a_r1_meas_lands: assert property (@(posedge clk) disable iff (rst)
        (upd.valid && upd.chan != CH_W'(PIN)) |=> status[$past(upd.chan)] == $past(upd.flag));
    // R5: pin bit follows the input
    a_r5_pin_tracks: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> status[PIN] == $past(pin));
    // R3: a zero write with no measurement changes nothing stored
    a_r3_zero_write: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata == '0 && !upd.valid) |=> (status & ~PIN_MSK) == $past(status & ~PIN_MSK));
    // R4: software bits written with one become set
    a_r4_sw_set: assert property (@(posedge clk) disable iff (rst)
        (wr && |(wdata & SET_MSK) && !upd.valid) |=> (status & $past(wdata & SET_MSK)) == $past(wdata & SET_MSK));
endmodule

// File: rtl/irq_out_gate.sv
module irq_out_gate #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] status,
    input  logic [N-1:0] mask,
    input  logic         enable,
    output logic         int_oe
);
    logic [N-1:0] live;
    assign live = status & ~mask;

    always_ff @(posedge clk) begin
        if (rst) int_oe <= 1'b0;
        else     int_oe <= enable & (|live);
    end

    // R8: disabled means released next cycle
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !int_oe);
    // R6: fully masked sources never pull the line
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        ((status & ~mask) == '0) |=> !int_oe);
    // R7: an enabled unmasked source pulls the line
    a_r7_pulls: assert property (@(posedge clk) disable iff (rst)
        (enable && (status & ~mask) != '0) |=> int_oe);
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              meas_valid,
    input  logic [CH_W-1:0]   meas_chan,
    input  logic [DATA_W-1:0] meas_value,
    input  logic [DATA_W-1:0] lim_hi,
    input  logic [DATA_W-1:0] lim_lo,
    input  logic              gpi,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [N_SRC-1:0]  reg_wdata,
    output logic [N_SRC-1:0]  reg_rdata,
    output logic              int_oe
);
    upd_t             upd;
    logic [N_SRC-1:0] status;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] cfg_q;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(reg_addr);

    irq_limit_cmp u_cmp (
        .valid (meas_valid),
        .chan  (meas_chan),
        .value (meas_value),
        .hi    (lim_hi),
        .lo    (lim_lo),
        .upd   (upd)
    );

    irq_status_bank #(.N(N_SRC), .PIN(PIN_IDX), .SET_MSK(SW_SET_BITS)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .wr     (reg_we && sel == SEL_STATUS),
        .wdata  (reg_wdata),
        .pin    (gpi),
        .status (status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            cfg_q  <= '0;
        end else if (reg_we) begin
            if (sel == SEL_MASK) mask_q <= reg_wdata;
            if (sel == SEL_CFG)  cfg_q  <= reg_wdata;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = status;
            SEL_MASK:   reg_rdata = mask_q;
            SEL_CFG:    reg_rdata = cfg_q;
            default:    reg_rdata = '0;
        endcase
    end

    irq_out_gate #(.N(N_SRC)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .status (status),
        .mask   (mask_q),
        .enable (cfg_q[EN_BIT]),
        .int_oe (int_oe)
    );

    // R10: unused address reads as zero
    a_r10_hole_zero: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> reg_rdata == '0);
endmodule

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_irq_status_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       meas_valid = 1'b0;
    logic [2:0] meas_chan = '0;
    logic [7:0] meas_value = '0, lim_hi = '0, lim_lo = '0;
    logic       gpi = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       int_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_ctrl dut (
        .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas_chan(meas_chan),
        .meas_value(meas_value), .lim_hi(lim_hi), .lim_lo(lim_lo), .gpi(gpi),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .int_oe(int_oe)
    );

    // {op(1: 0 meas, 1 write), idx(3), d(8), hi(8), lo(8), exp_status(8), exp_int(1), req(4)}
    localparam int NV = 17;
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 3'd2, 8'h02, 8'd0,   8'd0,  8'h00, 1'b0, 4'd7},  // R7 enable
        {1'b0, 3'd0, 8'd50, 8'd40,  8'd10, 8'h01, 1'b1, 4'd1},  // R1 above high
        {1'b0, 3'd5, 8'd5,  8'd40,  8'd10, 8'h21, 1'b1, 4'd1},  // R1 below low
        {1'b0, 3'd0, 8'd40, 8'd40,  8'd10, 8'h20, 1'b1, 4'd1},  // R1 equal high
        {1'b0, 3'd5, 8'd10, 8'd40,  8'd10, 8'h00, 1'b0, 4'd1},  // R1 equal low
        {1'b0, 3'd7, 8'd200,8'd100, 8'd0,  8'h80, 1'b1, 4'd2},  // R2 diode bit
        {1'b1, 3'd0, 8'h00, 8'd0,   8'd0,  8'h80, 1'b1, 4'd3},  // R3 zero write
        {1'b1, 3'd0, 8'h80, 8'd0,   8'd0,  8'h00, 1'b0, 4'd3},  // R3 clear
        {1'b1, 3'd0, 8'h06, 8'd0,   8'd0,  8'h06, 1'b1, 4'd4},  // R4 sw set
        {1'b1, 3'd1, 8'h06, 8'd0,   8'd0,  8'h06, 1'b0, 4'd6},  // R6 mask sw
        {1'b0, 3'd3, 8'd99, 8'd50,  8'd0,  8'h0E, 1'b1, 4'd2},  // R2 thermal bit
        {1'b1, 3'd1, 8'hFF, 8'd0,   8'd0,  8'h0E, 1'b0, 4'd6},  // R6 mask all
        {1'b1, 3'd1, 8'h00, 8'd0,   8'd0,  8'h0E, 1'b1, 4'd6},  // R6 unmask
        {1'b1, 3'd2, 8'h00, 8'd0,   8'd0,  8'h0E, 1'b0, 4'd8},  // R8 disable
        {1'b1, 3'd2, 8'h02, 8'd0,   8'd0,  8'h0E, 1'b1, 4'd7},  // R7 re-enable
        {1'b0, 3'd4, 8'd255,8'd0,   8'd0,  8'h0E, 1'b1, 4'd5},  // R5 meas ignored
        {1'b1, 3'd0, 8'hFF, 8'd0,   8'd0,  8'h06, 1'b1, 4'd3}   // R3 R4 all ones
    };

    task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic op, input logic [2:0] idx, input logic [7:0] d,
                        input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk);
        if (op) begin
            reg_we = 1'b1; reg_addr = idx[1:0]; reg_wdata = d;
        end else begin
            meas_valid = 1'b1; meas_chan = idx; meas_value = d; lim_hi = hi; lim_lo = lo;
        end
        @(negedge clk);
        reg_we = 1'b0; meas_valid = 1'b0; reg_addr = 2'd0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        reg_addr = 2'd0; #0.1 chk(10, reg_rdata, 8'h00, "status after reset");
        reg_addr = 2'd1; #0.1 chk(10, reg_rdata, 8'h00, "mask after reset");
        reg_addr = 2'd2; #0.1 chk(10, reg_rdata, 8'h00, "config after reset");
        reg_addr = 2'd3; #0.1 chk(10, reg_rdata, 8'h00, "hole read");
        chk(10, {7'd0, int_oe}, 8'h00, "int after reset");
        reg_addr = 2'd0;

        for (int i = 0; i < NV; i++) begin
            logic [40:0] v;
            v = VEC[i];
            step(v[40], v[39:37], v[36:29], v[28:21], v[20:13]);
            chk(int'(v[3:0]), reg_rdata, v[12:5], $sformatf("status vec %0d", i));
            chk(int'(v[3:0]), {7'd0, int_oe}, {7'd0, v[4]}, $sformatf("int vec %0d", i));
        end

        // R5: pin tracking and write immunity; mask sw bits first
        step(1'b1, 3'd1, 8'h06, 8'd0, 8'd0);
        chk(6, {7'd0, int_oe}, 8'h00, "sw bits masked");
        @(negedge clk); gpi = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(5, reg_rdata, 8'h16, "pin high");
        chk(5, {7'd0, int_oe}, 8'h01, "pin drives int");
        step(1'b1, 3'd0, 8'h10, 8'd0, 8'd0);
        chk(5, reg_rdata, 8'h16, "pin bit ignores write");
        @(negedge clk); gpi = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(5, reg_rdata, 8'h06, "pin low");

        // R9: measurement beats a clear on bit 0
        @(negedge clk);
        meas_valid = 1'b1; meas_chan = 3'd0; meas_value = 8'd90; lim_hi = 8'd80; lim_lo = 8'd0;
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h01;
        @(negedge clk);
        meas_valid = 1'b0; reg_we = 1'b0;
        #0.1 chk(9, reg_rdata, 8'h07, "meas wins over clear");
        // R9: in-limit measurement beats a software set on bit 1
        step(1'b1, 3'd0, 8'h02, 8'd0, 8'd0);
        @(negedge clk);
        meas_valid = 1'b1; meas_chan = 3'd1; meas_value = 8'd20; lim_hi = 8'd80; lim_lo = 8'd0;
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h02;
        @(negedge clk);
        meas_valid = 1'b0; reg_we = 1'b0;
        #0.1 chk(9, reg_rdata, 8'h05, "meas clears over sw set");

        // R8: status unchanged after disable
        step(1'b1, 3'd2, 8'h00, 8'd0, 8'd0);
        chk(8, reg_rdata, 8'h05, "status kept on disable");
        chk(8, {7'd0, int_oe}, 8'h00, "released on disable");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule